// File: doc/BRIEF.md
# Version-Matched Operand Wakeup Window

This block is the wakeup part of an out-of-order instruction window. Each of its entries holds up to two source operands. Each operand records three things: the physical register tag it waits on, the 2-bit data version it expects to read (taken at rename time), and whether it is ready. A completing producer broadcasts its destination tag together with the version it wrote. An operand wakes only when both the tag and the version match. Several in-flight producers may reuse one physical register, and each of them wakes only the consumer of its own version.

Two broadcast ports are compared against every waiting operand in parallel. An entry is written through an insert port and cleared by an issue strobe that carries its index. The block reports a vector with one bit per entry, set when that entry is occupied and all of its used operands are ready. Choosing among the ready entries is left to the logic outside the block.

Each entry runs a two-state machine: `ENT_FREE` moves to `ENT_BUSY` on insert, and `ENT_BUSY` moves back to `ENT_FREE` on issue. An insert to an entry takes it to `ENT_BUSY` from either state. Each operand runs its own two-state machine: `OP_WAIT` moves to `OP_READY` on a tag-and-version hit. On insert the operand is loaded directly into `OP_READY` or into `OP_WAIT`.

Top module: `wakeup_window`

## Requirements
- R1: After reset, every bit of `entry_ready` is 0.
- R2: An inserted entry whose used operands do not all match is not ready. Bit i of `entry_ready` is 1 exactly when entry i is occupied and all of its used operands are ready. The bit reflects the clock edge that performed the insert or wakeup.
- R3: A source operand inserted with its bit in `ins_src_used` at 0 is ready on insertion. Operand s occupies tag bits [s*TAG_W +: TAG_W] and version bits [s*2 +: 2].
- R4: A valid broadcast wakes a waiting operand only if the broadcast tag equals the stored tag and the broadcast version equals the stored version. A broadcast that matches the tag but not the version leaves the operand waiting.
- R5: Either of the two broadcast ports can wake an operand. The two operands of one entry can be woken in the same cycle by different ports. Port b uses tag bits [b*TAG_W +: TAG_W] and version bits [b*2 +: 2].
- R6: An operand inserted in the same cycle as a valid matching broadcast is ready on insertion.
- R7: An issue strobe with index i clears entry i, so its ready bit is 0 after that edge. Later broadcasts do not set the bit again until the entry is inserted anew.
- R8: When insert and issue name the same index in the same cycle, the insert takes effect.
- R9: A ready bit rises only through an insert or a matching valid broadcast. A ready bit stays set until its entry is issued or inserted again.
- R10: A broadcast port whose bit in `bc_valid` is 0 wakes nothing, whatever its tag and version.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert strobe |
| ins_idx | input | IDX_W | Entry written by the insert |
| ins_src_used | input | NSRC | Per-operand use flags |
| ins_src_tag | input | NSRC*TAG_W | Per-operand physical tags |
| ins_src_ver | input | NSRC*2 | Per-operand expected versions |
| bc_valid | input | NBC | Per-port broadcast valid |
| bc_tag | input | NBC*TAG_W | Broadcast destination tags |
| bc_ver | input | NBC*2 | Broadcast written versions |
| iss_valid | input | 1 | Issue strobe |
| iss_idx | input | IDX_W | Entry cleared by the issue |
| entry_ready | output | ENTRIES | Per-entry all-operands-ready flag |

## Verification
Every result is due one clock edge after its stimulus: insert, wakeup and issue all act through state registers, and `entry_ready` is decoded from those registers. The bench drives inputs on the falling edge and updates its reference model from the same input values. It then waits for the rising edge and compares the whole ready vector at the next falling edge. The same-cycle cases (insert with broadcast, insert with issue) are directed tests. A long random run over a small tag and version space produces frequent partial matches.

// File: rtl/wkw_pkg.sv
package wkw_pkg;
    localparam int VER_W = 2;

    typedef enum logic {
        OP_WAIT  = 1'b0,
        OP_READY = 1'b1
    } op_state_e;

    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_BUSY = 1'b1
    } ent_state_e;
endpackage

// File: rtl/wkw_match.sv
module wkw_match
    import wkw_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int NBC   = 2
) (
    input  logic [TAG_W-1:0]     tag,
    input  logic [VER_W-1:0]     ver,
    input  logic [NBC-1:0]       bc_valid,
    input  logic [NBC*TAG_W-1:0] bc_tag,
    input  logic [NBC*VER_W-1:0] bc_ver,
    output logic                 hit
);
    logic [NBC-1:0] port_hit;

    for (genvar b = 0; b < NBC; b++) begin : g_port
        assign port_hit[b] = bc_valid[b]
                           && (bc_tag[b*TAG_W +: TAG_W] == tag)
                           && (bc_ver[b*VER_W +: VER_W] == ver);
    end

    assign hit = |port_hit;
endmodule

// File: rtl/wkw_operand.sv
module wkw_operand
    import wkw_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int NBC   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 used,
    input  logic [TAG_W-1:0]     tag_in,
    input  logic [VER_W-1:0]     ver_in,
    input  logic [NBC-1:0]       bc_valid,
    input  logic [NBC*TAG_W-1:0] bc_tag,
    input  logic [NBC*VER_W-1:0] bc_ver,
    output logic                 rdy
);
    op_state_e        state_q, state_d;
    logic [TAG_W-1:0] tag_q;
    logic [VER_W-1:0] ver_q;
    logic             hit_new, hit_held;

    wkw_match #(.TAG_W(TAG_W), .NBC(NBC)) u_match_new (
        .tag(tag_in), .ver(ver_in), .bc_valid(bc_valid),
        .bc_tag(bc_tag), .bc_ver(bc_ver), .hit(hit_new)
    );

    wkw_match #(.TAG_W(TAG_W), .NBC(NBC)) u_match_held (
        .tag(tag_q), .ver(ver_q), .bc_valid(bc_valid),
        .bc_tag(bc_tag), .bc_ver(bc_ver), .hit(hit_held)
    );

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (!used || hit_new) ? OP_READY : OP_WAIT;
        end else begin
            unique case (state_q)
                OP_WAIT:  if (hit_held) state_d = OP_READY;
                OP_READY: state_d = OP_READY;
                default:  state_d = OP_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OP_READY;
            tag_q   <= '0;
            ver_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                tag_q <= tag_in;
                ver_q <= ver_in;
            end
        end
    end

    always_comb rdy = (state_q == OP_READY);
endmodule

// File: rtl/wkw_entry.sv
module wkw_entry
    import wkw_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int NSRC  = 2,
    parameter int NBC   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  clear,
    input  logic [NSRC-1:0]       src_used,
    input  logic [NSRC*TAG_W-1:0] src_tag,
    input  logic [NSRC*VER_W-1:0] src_ver,
    input  logic [NBC-1:0]        bc_valid,
    input  logic [NBC*TAG_W-1:0]  bc_tag,
    input  logic [NBC*VER_W-1:0]  bc_ver,
    output logic                  ready
);
    ent_state_e      state_q, state_d;
    logic [NSRC-1:0] src_rdy;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        wkw_operand #(.TAG_W(TAG_W), .NBC(NBC)) u_op (
            .clk(clk), .rst_n(rst_n), .load(load),
            .used(src_used[s]),
            .tag_in(src_tag[s*TAG_W +: TAG_W]),
            .ver_in(src_ver[s*VER_W +: VER_W]),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_ver(bc_ver),
            .rdy(src_rdy[s])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (load) state_d = ENT_BUSY;
            ENT_BUSY: if (!load && clear) state_d = ENT_FREE;
            default:  state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    always_comb ready = (state_q == ENT_BUSY) && (&src_rdy);
endmodule

// File: rtl/wakeup_window.sv
module wakeup_window
    import wkw_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 6,
    parameter int NSRC    = 2,
    parameter int NBC     = 2,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ins_valid,
    input  logic [IDX_W-1:0]      ins_idx,
    input  logic [NSRC-1:0]       ins_src_used,
    input  logic [NSRC*TAG_W-1:0] ins_src_tag,
    input  logic [NSRC*VER_W-1:0] ins_src_ver,
    input  logic [NBC-1:0]        bc_valid,
    input  logic [NBC*TAG_W-1:0]  bc_tag,
    input  logic [NBC*VER_W-1:0]  bc_ver,
    input  logic                  iss_valid,
    input  logic [IDX_W-1:0]      iss_idx,
    output logic [ENTRIES-1:0]    entry_ready
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic do_load, do_clear;
        assign do_load  = ins_valid && (ins_idx == IDX_W'(i));
        assign do_clear = iss_valid && (iss_idx == IDX_W'(i));

        wkw_entry #(.TAG_W(TAG_W), .NSRC(NSRC), .NBC(NBC)) u_entry (
            .clk(clk), .rst_n(rst_n),
            .load(do_load), .clear(do_clear),
            .src_used(ins_src_used), .src_tag(ins_src_tag),
            .src_ver(ins_src_ver),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_ver(bc_ver),
            .ready(entry_ready[i])
        );
    end
endmodule

// File: rtl/wakeup_window_chk.sv
module wakeup_window_chk #(
    parameter int ENTRIES = 8,
    parameter int NSRC    = 2,
    parameter int NBC     = 2,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_valid,
    input logic [IDX_W-1:0]   ins_idx,
    input logic [NSRC-1:0]    ins_src_used,
    input logic [NBC-1:0]     bc_valid,
    input logic               iss_valid,
    input logic [IDX_W-1:0]   iss_idx,
    input logic [ENTRIES-1:0] entry_ready
);
    p_unused_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_src_used == '0) |=> entry_ready[$past(ins_idx)]);

    p_issue_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !(ins_valid && ins_idx == iss_idx))
        |=> !entry_ready[$past(iss_idx)]);

    p_insert_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && ins_valid && ins_idx == iss_idx && ins_src_used == '0)
        |=> entry_ready[$past(iss_idx)]);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
        p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (entry_ready[i] && !(iss_valid && iss_idx == IDX_W'(i))
                            && !(ins_valid && ins_idx == IDX_W'(i)))
            |=> entry_ready[i]);

        p_no_cause_no_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid == '0 && !(ins_valid && ins_idx == IDX_W'(i)))
            |=> !$rose(entry_ready[i]));
    end
endmodule

bind wakeup_window wakeup_window_chk #(
    .ENTRIES(ENTRIES), .NSRC(NSRC), .NBC(NBC), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_idx(ins_idx),
    .ins_src_used(ins_src_used), .bc_valid(bc_valid),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .entry_ready(entry_ready)
);

// File: tb/wakeup_window_bench.sv
module wakeup_window_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 8;
    localparam int TAG_W   = 6;
    localparam int NSRC    = 2;
    localparam int NBC     = 2;
    localparam int VW      = 2;
    localparam int IDX_W   = 3;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  ins_valid;
    logic [IDX_W-1:0]      ins_idx;
    logic [NSRC-1:0]       ins_src_used;
    logic [NSRC*TAG_W-1:0] ins_src_tag;
    logic [NSRC*VW-1:0]    ins_src_ver;
    logic [NBC-1:0]        bc_valid;
    logic [NBC*TAG_W-1:0]  bc_tag;
    logic [NBC*VW-1:0]     bc_ver;
    logic                  iss_valid;
    logic [IDX_W-1:0]      iss_idx;
    logic [ENTRIES-1:0]    entry_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic             m_busy [ENTRIES];
    logic             m_rdy  [ENTRIES][NSRC];
    logic [TAG_W-1:0] m_tag  [ENTRIES][NSRC];
    logic [VW-1:0]    m_ver  [ENTRIES][NSRC];

    always #(CLK_PERIOD/2) clk = ~clk;

    wakeup_window u_wakeup_window (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_idx(ins_idx),
        .ins_src_used(ins_src_used), .ins_src_tag(ins_src_tag),
        .ins_src_ver(ins_src_ver), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .bc_ver(bc_ver), .iss_valid(iss_valid), .iss_idx(iss_idx),
        .entry_ready(entry_ready)
    );

    function automatic bit bc_hit(input logic [TAG_W-1:0] t, input logic [VW-1:0] v);
        bit h = 0;
        for (int b = 0; b < NBC; b++)
            if (bc_valid[b] && bc_tag[b*TAG_W +: TAG_W] == t && bc_ver[b*VW +: VW] == v)
                h = 1;
        return h;
    endfunction

    function automatic logic [ENTRIES-1:0] model_ready();
        logic [ENTRIES-1:0] r;
        for (int i = 0; i < ENTRIES; i++) begin
            r[i] = m_busy[i];
            for (int s = 0; s < NSRC; s++) r[i] = r[i] & m_rdy[i][s];
        end
        return r;
    endfunction

    task automatic model_step();
        for (int i = 0; i < ENTRIES; i++) begin
            if (ins_valid && ins_idx == IDX_W'(i)) begin
                m_busy[i] = 1;
                for (int s = 0; s < NSRC; s++) begin
                    m_tag[i][s] = ins_src_tag[s*TAG_W +: TAG_W];
                    m_ver[i][s] = ins_src_ver[s*VW +: VW];
                    m_rdy[i][s] = !ins_src_used[s] || bc_hit(m_tag[i][s], m_ver[i][s]);
                end
            end else begin
                if (iss_valid && iss_idx == IDX_W'(i)) m_busy[i] = 0;
                for (int s = 0; s < NSRC; s++)
                    if (!m_rdy[i][s] && bc_hit(m_tag[i][s], m_ver[i][s])) m_rdy[i][s] = 1;
            end
        end
    endtask

    task automatic compare(input string req);
        logic [ENTRIES-1:0] exp_v;
        exp_v = model_ready();
        n_cmp++;
        if (entry_ready !== exp_v) begin
            n_bad++;
            $display("FAIL %s: entry_ready actual %b expected %b", req, entry_ready, exp_v);
        end
    endtask

    task automatic idle_inputs();
        ins_valid = 0; ins_idx = '0; ins_src_used = '0; ins_src_tag = '0;
        ins_src_ver = '0; bc_valid = '0; bc_tag = '0; bc_ver = '0;
        iss_valid = 0; iss_idx = '0;
    endtask

    task automatic tick(input string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(req);
        idle_inputs();
    endtask

    task automatic put(input int idx, input logic [1:0] used,
                       input int t0, input int v0, input int t1, input int v1);
        ins_valid = 1; ins_idx = IDX_W'(idx); ins_src_used = used;
        ins_src_tag = {TAG_W'(t1), TAG_W'(t0)};
        ins_src_ver = {VW'(v1), VW'(v0)};
    endtask

    task automatic cast(input int port, input int t, input int v);
        bc_valid[port] = 1;
        bc_tag[port*TAG_W +: TAG_W] = TAG_W'(t);
        bc_ver[port*VW +: VW] = VW'(v);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rst_n = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            m_busy[i] = 0;
            for (int s = 0; s < NSRC; s++) begin
                m_rdy[i][s] = 1; m_tag[i][s] = '0; m_ver[i][s] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1 reset");

        // R2: entry 0 waits on tag 5 ver 1 and tag 6 ver 2
        put(0, 2'b11, 5, 1, 6, 2); tick("R2 insert waiting");
        // R4: tag match with wrong version does not wake
        cast(0, 5, 2); cast(1, 6, 1); tick("R4 version mismatch");
        // R10: matching values with valid low
        bc_tag = {TAG_W'(6), TAG_W'(5)}; bc_ver = {VW'(2), VW'(1)}; tick("R10 invalid port");
        // R5: both operands woken by different ports in one cycle
        cast(0, 5, 1); cast(1, 6, 2); tick("R5 dual port wake");
        // R3: no used operands
        put(1, 2'b00, 0, 0, 0, 0); tick("R3 unused operands");
        // R7: issue clears, later matching broadcast does not revive
        iss_valid = 1; iss_idx = 3'd1; tick("R7 issue clear");
        cast(0, 0, 0); tick("R7 no revive");
        // R6: insert with same-cycle matching broadcast on port 1
        put(2, 2'b01, 9, 3, 0, 0); cast(1, 9, 3); tick("R6 same cycle wake");
        // R8: insert and issue same index
        iss_valid = 1; iss_idx = 3'd3; put(3, 2'b00, 0, 0, 0, 0); tick("R8 insert wins");
        // R4: one in-flight producer per version of the same register
        put(4, 2'b01, 7, 0, 0, 0); tick("R2 insert v0");
        put(5, 2'b01, 7, 1, 0, 0); tick("R2 insert v1");
        cast(0, 7, 1); tick("R4 only v1 wakes");
        cast(1, 7, 0); tick("R4 v0 wakes");

        // R9: random mix over a small tag/version space
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 2) == 0)
                put($urandom_range(0, ENTRIES-1), 2'($urandom_range(0, 3)),
                    $urandom_range(0, 3), $urandom_range(0, 3),
                    $urandom_range(0, 3), $urandom_range(0, 3));
            for (int b = 0; b < NBC; b++)
                if ($urandom_range(0, 1) == 1)
                    cast(b, $urandom_range(0, 3), $urandom_range(0, 3));
                else begin
                    bc_tag[b*TAG_W +: TAG_W] = TAG_W'($urandom_range(0, 3));
                    bc_ver[b*VW +: VW] = VW'($urandom_range(0, 3));
                end
            if ($urandom_range(0, 3) == 0) begin
                iss_valid = 1; iss_idx = IDX_W'($urandom_range(0, ENTRIES-1));
            end
            tick("R9 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule